// File: doc/BRIEF.md
# Half-Period Slave Delay Scheduler

This block times the second phase of a two-phase interleaved converter whose switching frequency moves cycle by cycle. A master gate comes from elsewhere. The block measures the master switching period in system clocks, from one master turn-on to the next. It then places the slave turn-on half a period after each master turn-on, so the two phases stay 180 degrees apart without any feedback from the slave phase.

The delay is refreshed only once per fixed control frame, using the last complete period measurement. Half of an odd period is not a whole number of clocks. The block splits the delay into a whole-clock count and a half-clock extension flag. When the flag is set, the slave gate is re-timed by a register on the falling clock edge, so the total delay is exactly half the period in steady state. The flag is also brought out, so a later stage knows the edge sits mid-clock.

Once the slave turns on, it stays on for the commanded on-time, counted in clocks. A measured period that is shorter than twice the on-time, or longer than the accepted maximum, is rejected. In that case the previous delay stays in force and an error flag is raised.

Top module: `hs_slave_sched`

## Requirements
- R1: The master period is the number of clock edges between two consecutive sampled rising edges of `master_on_i`. The first rising edge after reset only starts the count and yields no usable period.
- R2: For an accepted even period P, the slave gate rises P/2 clock edges after the edge that sampled the master turn-on, and `half_ext_o` is 0.
- R3: For an accepted odd period P, the whole-clock delay is (P-1)/2 and `half_ext_o` is 1. The slave gate is then delayed by a further half clock: it changes on the falling clock edge, so its rising edge comes P half-clocks after the master turn-on sampling edge.
- R4: Once risen, the slave gate stays high for exactly `ton_i` clocks, which is 2*`ton_i` half-clocks.
- R5: A new delay is computed once every FRAME clocks from the latest period, and is applied only at the next master turn-on. `half_ext_o` changes only at a master turn-on.
- R6: Until a first delay has been accepted, the slave gate stays low.
- R7: A period below 2*`ton_i`, or above PMAX (default 4000), keeps the previous delay and half-clock flag and sets `period_err_o` to 1. The next accepted refresh clears `period_err_o`.
- R8: The period counter saturates at its all-ones value (4095 for the default 12-bit width) and does not wrap. A master gap of 4196 clocks therefore reads as an over-range period.
- R9: While `rst_ni` is low, all outputs are 0.
- R10: A master turn-on during the slave delay or on-time forces the slave gate low and restarts the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_on_i | input | 1 | Master gate level; a sampled rising edge marks turn-on |
| ton_i | input | CW (12) | Commanded on-time in clocks |
| slave_gate_o | output | 1 | Slave gate, half-clock shifted when the extension is active |
| half_ext_o | output | 1 | 1 when the applied delay carries an extra half clock |
| period_err_o | output | 1 | Last refresh rejected the measured period |

## Verification
A corrupted period count or delay register does not show until the next frame refresh, and then only at the following master turn-on. From then on the slave pulse sits at the wrong half-clock position in every period. The bench therefore samples the slave gate twice per clock, once between the rising and falling edges and once after the falling edge. It compares the whole period against the ideal pulse window of P to P+2*ton half-clocks. A wrong parity decision shows immediately on `half_ext_o` and as a one-half-clock shift of both pulse edges. Wrapping or rejection faults surface as a wrong `period_err_o` level within one frame of the offending period.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    SLV_IDLE = 2'd0,
    SLV_WAIT = 2'd1,
    SLV_ON   = 2'd2
  } slv_state_e;

  localparam int unsigned FRAME_DEF = 240;
endpackage

// File: rtl/hs_period_meter.sv
module hs_period_meter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_on_i,
  output logic          rise_o,
  output logic [CW-1:0] meas_o,
  output logic          meas_vld_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          prev_q, seen_q, vld_q;
  logic [CW-1:0] cnt_q, meas_q;

  assign rise_o     = master_on_i & ~prev_q;
  assign meas_o     = meas_q;
  assign meas_vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      meas_q <= '0;
    end else begin
      prev_q <= master_on_i;
      if (rise_o) begin
        meas_q <= cnt_q;
        vld_q  <= seen_q;
        seen_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  p_cnt_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> cnt_q == CW'(1));
  p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rise_o) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/hs_delay_calc.sv
module hs_delay_calc #(
  parameter int unsigned CW    = 12,
  parameter int unsigned FRAME = 240,
  parameter int unsigned PMAX  = 4000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] meas_i,
  input  logic          meas_vld_i,
  input  logic [CW-1:0] ton_i,
  output logic [CW-1:0] pend_dly_o,
  output logic          pend_ext_o,
  output logic          pend_vld_o,
  output logic          err_o
);
  localparam int unsigned FW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [FW-1:0] FR_LAST = FW'(FRAME - 1);
  localparam logic [CW:0]   PMAX_V  = (CW+1)'(PMAX);

  logic [FW-1:0] fr_q;
  logic          tick;
  logic          too_short, too_long, reject;
  logic [CW:0]   ton2;

  assign tick      = (fr_q == FR_LAST);
  assign ton2      = {ton_i, 1'b0};
  assign too_short = {1'b0, meas_i} < ton2;
  assign too_long  = {1'b0, meas_i} > PMAX_V;
  assign reject    = too_short | too_long;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fr_q <= '0;
    else if (tick) fr_q <= '0;
    else fr_q <= fr_q + FW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_dly_o <= '0;
      pend_ext_o <= 1'b0;
      pend_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else if (tick && meas_vld_i) begin
      if (reject) begin
        err_o <= 1'b1;
      end else begin
        pend_dly_o <= meas_i >> 1;
        pend_ext_o <= meas_i[0];
        pend_vld_o <= 1'b1;
        err_o      <= 1'b0;
      end
    end
  end

  p_keep_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($stable(pend_dly_o) && $stable(pend_ext_o)));
  p_refresh_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ($stable(pend_dly_o) && $stable(err_o)));
endmodule

// File: rtl/hs_slave_timer.sv
module hs_slave_timer
  import hs_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [CW-1:0] pend_dly_i,
  input  logic          pend_ext_i,
  input  logic          pend_vld_i,
  input  logic [CW-1:0] ton_i,
  output logic          gate_o,
  output logic          ext_o
);
  slv_state_e    st_q;
  logic [CW-1:0] dcnt_q, oncnt_q, act_dly_q;
  logic          act_ext_q, act_vld_q;

  assign ext_o = act_ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SLV_IDLE;
      dcnt_q    <= '0;
      oncnt_q   <= '0;
      act_dly_q <= '0;
      act_ext_q <= 1'b0;
      act_vld_q <= 1'b0;
      gate_o    <= 1'b0;
    end else if (rise_i) begin
      gate_o <= 1'b0;
      if (pend_vld_i) begin
        act_dly_q <= pend_dly_i;
        act_ext_q <= pend_ext_i;
        act_vld_q <= 1'b1;
        dcnt_q    <= pend_dly_i;
        st_q      <= SLV_WAIT;
      end else begin
        st_q <= SLV_IDLE;
      end
    end else begin
      unique case (st_q)
        SLV_WAIT: begin
          if (dcnt_q <= CW'(1)) begin
            if (ton_i != '0) begin
              gate_o  <= 1'b1;
              oncnt_q <= ton_i;
              st_q    <= SLV_ON;
            end else begin
              st_q <= SLV_IDLE;
            end
          end else begin
            dcnt_q <= dcnt_q - CW'(1);
          end
        end
        SLV_ON: begin
          if (oncnt_q <= CW'(1)) begin
            gate_o <= 1'b0;
            st_q   <= SLV_IDLE;
          end else begin
            oncnt_q <= oncnt_q - CW'(1);
          end
        end
        default: st_q <= SLV_IDLE;
      endcase
    end
  end

  p_apply_at_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> ($stable(act_dly_q) && $stable(act_ext_q)));
  p_no_gate_unarmed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_vld_q |-> !gate_o);
  p_rise_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !gate_o);
  p_on_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> st_q == SLV_ON);
endmodule

// File: rtl/hs_half_shift.sv
module hs_half_shift (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic ext_i,
  output logic gate_o
);
  logic gate_n_q;

  // re-time on the falling edge for the half-clock extension
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_n_q <= 1'b0;
    else gate_n_q <= gate_i;
  end

  assign gate_o = ext_i ? gate_n_q : gate_i;

  p_half_follow_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> gate_n_q == $past(gate_i));
endmodule

// File: rtl/hs_slave_sched.sv
module hs_slave_sched #(
  parameter int unsigned CW    = 12,
  parameter int unsigned FRAME = hs_pkg::FRAME_DEF,
  parameter int unsigned PMAX  = 4000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_on_i,
  input  logic [CW-1:0] ton_i,
  output logic          slave_gate_o,
  output logic          half_ext_o,
  output logic          period_err_o
);
  logic          rise;
  logic [CW-1:0] meas;
  logic          meas_vld;
  logic [CW-1:0] pend_dly;
  logic          pend_ext, pend_vld;
  logic          gate_pos;

  hs_period_meter #(.CW(CW)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_on_i(master_on_i),
    .rise_o     (rise),
    .meas_o     (meas),
    .meas_vld_o (meas_vld)
  );

  hs_delay_calc #(.CW(CW), .FRAME(FRAME), .PMAX(PMAX)) u_calc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_i     (meas),
    .meas_vld_i (meas_vld),
    .ton_i      (ton_i),
    .pend_dly_o (pend_dly),
    .pend_ext_o (pend_ext),
    .pend_vld_o (pend_vld),
    .err_o      (period_err_o)
  );

  hs_slave_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .pend_dly_i (pend_dly),
    .pend_ext_i (pend_ext),
    .pend_vld_i (pend_vld),
    .ton_i      (ton_i),
    .gate_o     (gate_pos),
    .ext_o      (half_ext_o)
  );

  hs_half_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_pos),
    .ext_i  (half_ext_o),
    .gate_o (slave_gate_o)
  );

  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(half_ext_o));
  always_comb begin
    if (!rst_ni) p_reset_quiet_r9: assert (!slave_gate_o && !half_ext_o && !period_err_o);
  end
endmodule

// File: tb/hs_slave_sched_tb.sv
module hs_slave_sched_tb;
  localparam int CW    = 12;
  localparam int FRAME = 240;
  localparam int NV    = 8;
  localparam int VP[NV] = '{20, 21, 30, 31, 40, 7, 64, 101};
  localparam int VT[NV] = '{5, 5, 10, 15, 20, 3, 1, 50};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          master_on = 1'b0;
  logic [CW-1:0] ton = '0;
  logic          slave_gate, half_ext, period_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hs_slave_sched u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .master_on_i (master_on),
    .ton_i       (ton),
    .slave_gate_o(slave_gate),
    .half_ext_o  (half_ext),
    .period_err_o(period_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one master period; returns number of half-clock samples off the ideal window
  task automatic run_period(input int p, input int t, input bit expect_low, output int bad);
    bad = 0;
    ton = CW'(t);
    for (int k = 0; k < p; k++) begin
      @(posedge clk);
      #2 master_on = (k < t);
      for (int h = 0; h < 2; h++) begin
        int jj;
        bit exp;
        if (h == 0) #3; else #10;
        jj  = (2 * (k - 1) + h + 2 * p) % (2 * p);
        exp = !expect_low && (jj >= p) && (jj < p + 2 * t);
        if (slave_gate !== exp) bad++;
      end
    end
  endtask

  task automatic run_n(input int p, input int t, input int n);
    int b;
    for (int i = 0; i < n; i++) run_period(p, t, 1'b0, b);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2 master_on = 1'b0;
    end
  endtask

  initial begin
    int bad;
    int warm;
    repeat (3) @(posedge clk);
    #5;
    chk(slave_gate === 1'b0, "R9 gate in reset", slave_gate, 0);
    chk(half_ext === 1'b0, "R9 ext in reset", half_ext, 0);
    chk(period_err === 1'b0, "R9 err in reset", period_err, 0);
    @(posedge clk);
    #2 rst_ni = 1'b1;

    // R6: well inside the first frame, no delay accepted yet
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      int b;
      run_period(20, 5, 1'b1, b);
      bad += b;
    end
    chk(bad == 0, "R6 no pulse before first delay", bad, 0);

    // vector table: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      warm = (FRAME + 3 * VP[v]) / VP[v] + 2;
      run_n(VP[v], VT[v], warm);
      run_period(VP[v], VT[v], 1'b0, bad);
      chk(bad == 0, (VP[v] % 2 == 0) ? "R2 R4 R1 even pulse window" : "R3 R4 R1 odd pulse window", bad, 0);
      chk(half_ext === 1'(VP[v] % 2), "R3 R2 half ext flag", half_ext, VP[v] % 2);
      chk(period_err === 1'b0, "R7 no error on valid period", period_err, 0);
    end

    // R7: period below twice on-time keeps the old even delay
    run_n(20, 5, (FRAME + 60) / 20 + 2);
    chk(half_ext === 1'b0, "R7 baseline even", half_ext, 0);
    bad = 0;
    for (int i = 0; i < (FRAME + 27) / 9 + 3; i++) begin
      int b;
      run_period(9, 5, 1'b1, b);
      bad += b;
    end
    chk(period_err === 1'b1, "R7 short period flagged", period_err, 1);
    chk(half_ext === 1'b0, "R7 previous flag kept", half_ext, 0);
    chk(bad == 0, "R7 old delay kept, no pulse fits", bad, 0);
    run_n(20, 5, (FRAME + 60) / 20 + 2);
    chk(period_err === 1'b0, "R7 error cleared on accepted refresh", period_err, 0);

    // R8: long gap saturates the counter and reads over range
    run_n(20, 5, 1);
    gap(4196);
    ton = CW'(5);
    @(posedge clk);
    #2 master_on = 1'b1;
    @(posedge clk);
    #2 master_on = 1'b0;
    gap(FRAME + 20);
    #3;
    chk(period_err === 1'b1, "R8 saturated period rejected", period_err, 1);
    chk(half_ext === 1'b0, "R8 delay unchanged", half_ext, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule